// File: doc/BRIEF.md
# DAC Sample-and-Hold Refresh Clock Generator

This block drives the sample clock of a DAC whose output voltage is held on a sample-and-hold capacitor. A programmable divider turns the system clock into a base tick. Each sample clock period has a high part and a low part, and both are counted in base ticks. When the block is enabled, it first produces a burst of back-to-back periods so the capacitor can charge to the programmed level. It then moves to a hold regime, in which it emits one refresh period after each idle gap. The gap length is counted in whole sample clock periods.

All timing fields are plain inputs. The block takes a fresh copy of them only at period boundaries, so a field change cannot cut a pulse short. When both the high time and the low time are zero, the block does not lock up. It keeps the clock output low, and it resumes normal output once a non-zero period is programmed. The block does not check the analog timing limits; software must respect them. Two status outputs report whether the block is in the charging burst or in the refresh regime.

Top module: `dac_shclk_gen`

## Requirements
- R1: After reset, with `enable` low, `smpl_clk`, `in_setup` and `in_hold` are all 0.
- R2: The base tick occurs once every `cfg_div`+1 system clocks. A high part lasts `cfg_high`×(`cfg_div`+1) cycles and a low part lasts `cfg_low`×(`cfg_div`+1) cycles.
- R3: In the first cycle after `enable` is sampled high from idle, `in_setup` is 1. If `cfg_high` is non-zero, `smpl_clk` is also 1 in that cycle, because a period always begins with its high part.
- R4: The charging burst lasts max(`cfg_setup`,1) full periods with no gaps between them, and `in_setup` stays 1 for exactly that long.
- R5: After the burst, `in_hold` is 1 and stays 1 while enabled. Each hold cycle is first an idle-low gap of `cfg_hold`×(`cfg_high`+`cfg_low`) base ticks and then one full period. If `cfg_hold` is 0, periods follow each other with no gap.
- R6: With `cfg_high`=0 and `cfg_low`>0, the output stays low for every period. With `cfg_low`=0 and `cfg_high`>0, the output stays high during periods.
- R7: With `cfg_high`=`cfg_low`=0, `smpl_clk` stays static low and `in_hold` stays 0. Once a non-zero period is programmed, output resumes at the next base tick.
- R8: In the cycle after `enable` is sampled low, all three outputs are 0. A later enable always restarts from the charging burst.
- R9: Timing fields are captured only at the start of a period. A change made in the middle of a period leaves the current high and low widths unchanged.
- R10: `in_setup` and `in_hold` are never 1 together. While the block runs, `smpl_clk` changes only in the cycle after a base tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; low forces idle |
| cfg_div | input | DIV_W | Base tick divider, tick every cfg_div+1 clocks |
| cfg_high | input | HI_W | High part length in base ticks |
| cfg_low | input | LO_W | Low part length in base ticks |
| cfg_hold | input | HOLD_W | Idle gap in sample clock periods |
| cfg_setup | input | SETUP_W | Number of charging periods (0 treated as 1) |
| smpl_clk | output | 1 | Sample clock to the sample-and-hold switch |
| in_setup | output | 1 | Charging burst in progress |
| in_hold | output | 1 | Refresh regime in progress |

## Verification
Randomly drawn settings of divider, high time, low time, gap and burst length are each compared cycle by cycle with a closed-form expected waveform and status trace. A mismatch there separates errors in tick spacing, in burst length and in gap placement. Directed cases cover a zero high time and a zero low time, the all-zero parked setting followed by a recovery, and a mid-period change of the high time. The mid-period case tells capture at period boundaries apart from immediate use of the new value. Each run ends with a disable check, and the next run starts from idle, which shows that every restart begins at the burst.

// File: rtl/shclk_pkg.sv
package shclk_pkg;

    typedef enum logic [1:0] {
        RUN_IDLE  = 2'd0,
        RUN_SETUP = 2'd1,
        RUN_HOLD  = 2'd2
    } run_e;

    typedef enum logic [1:0] {
        PH_PARK = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2,
        PH_GAP  = 2'd3
    } ph_e;

endpackage

// File: rtl/shclk_tick.sv
module shclk_tick #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] lim,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q >= lim);
        cnt_d = cnt_q;
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/shclk_seq.sv
module shclk_seq
    import shclk_pkg::*;
#(
    parameter int DIV_W   = 6,
    parameter int HI_W    = 4,
    parameter int LO_W    = 4,
    parameter int HOLD_W  = 4,
    parameter int SETUP_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               tick,
    input  logic [DIV_W-1:0]   cfg_div,
    input  logic [HI_W-1:0]    cfg_high,
    input  logic [LO_W-1:0]    cfg_low,
    input  logic [HOLD_W-1:0]  cfg_hold,
    input  logic [SETUP_W-1:0] cfg_setup,
    output logic               running,
    output logic [DIV_W-1:0]   div_lim,
    output logic               smpl_clk,
    output logic               in_setup,
    output logic               in_hold
);

    localparam int CNT_W = HOLD_W + HI_W + LO_W + 1;
    localparam int NPW   = SETUP_W + 1;

    typedef struct packed {
        run_e               run;
        ph_e                ph;
        logic [CNT_W-1:0]   cnt;
        logic [SETUP_W-1:0] nper;
        logic [DIV_W-1:0]   div;
        logic [HI_W-1:0]    hi;
        logic [LO_W-1:0]    lo;
        logic [HOLD_W-1:0]  hold;
        logic [SETUP_W-1:0] setup;
    } st_t;

    st_t st_d, st_q;

    logic [CNT_W-1:0] ph_len;
    logic [CNT_W:0]   cnt_inc;
    logic [NPW-1:0]   setup_eff;
    logic [NPW-1:0]   nper_inc;
    logic             ph_last;
    logic             per_end;
    logic             new_per;

    always_comb begin
        unique case (st_q.ph)
            PH_HIGH: ph_len = CNT_W'(st_q.hi);
            PH_LOW:  ph_len = CNT_W'(st_q.lo);
            PH_GAP:  ph_len = CNT_W'(st_q.hold) * (CNT_W'(st_q.hi) + CNT_W'(st_q.lo));
            default: ph_len = CNT_W'(1);
        endcase
        cnt_inc   = {1'b0, st_q.cnt} + 1'b1;
        ph_last   = tick && (cnt_inc >= {1'b0, ph_len});
        setup_eff = (st_q.setup == '0) ? NPW'(1) : NPW'(st_q.setup);
        nper_inc  = NPW'(st_q.nper) + 1'b1;

        st_d    = st_q;
        per_end = 1'b0;
        new_per = 1'b0;

        if (!enable) begin
            st_d.run  = RUN_IDLE;
            st_d.ph   = PH_PARK;
            st_d.cnt  = '0;
            st_d.nper = '0;
        end else if (st_q.run == RUN_IDLE) begin
            st_d.run  = RUN_SETUP;
            st_d.nper = '0;
            new_per   = 1'b1;
        end else if (tick) begin
            if (st_q.ph == PH_PARK) begin
                new_per = 1'b1;
            end else if (!ph_last) begin
                st_d.cnt = cnt_inc[CNT_W-1:0];
            end else begin
                unique case (st_q.ph)
                    PH_HIGH: begin
                        if (st_q.lo != '0) begin
                            st_d.ph  = PH_LOW;
                            st_d.cnt = '0;
                        end else begin
                            per_end = 1'b1;
                        end
                    end
                    PH_LOW:  per_end = 1'b1;
                    default: new_per = 1'b1;
                endcase
            end

            if (per_end) begin
                if ((st_q.run == RUN_SETUP) && (nper_inc < setup_eff)) begin
                    st_d.nper = nper_inc[SETUP_W-1:0];
                    new_per   = 1'b1;
                end else begin
                    st_d.run = RUN_HOLD;
                    if (st_q.hold != '0) begin
                        st_d.ph  = PH_GAP;
                        st_d.cnt = '0;
                    end else begin
                        new_per = 1'b1;
                    end
                end
            end
        end

        if (new_per) begin
            st_d.div   = cfg_div;
            st_d.hi    = cfg_high;
            st_d.lo    = cfg_low;
            st_d.hold  = cfg_hold;
            st_d.setup = cfg_setup;
            st_d.cnt   = '0;
            if (cfg_high != '0) begin
                st_d.ph = PH_HIGH;
            end else if (cfg_low != '0) begin
                st_d.ph = PH_LOW;
            end else begin
                st_d.ph = PH_PARK;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{run: RUN_IDLE, ph: PH_PARK, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign running  = (st_q.run != RUN_IDLE);
    assign div_lim  = st_q.div;
    assign smpl_clk = (st_q.ph == PH_HIGH);
    assign in_setup = (st_q.run == RUN_SETUP);
    assign in_hold  = (st_q.run == RUN_HOLD);

endmodule

// File: rtl/dac_shclk_gen.sv
module dac_shclk_gen #(
    parameter int DIV_W   = 6,
    parameter int HI_W    = 4,
    parameter int LO_W    = 4,
    parameter int HOLD_W  = 4,
    parameter int SETUP_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [DIV_W-1:0]   cfg_div,
    input  logic [HI_W-1:0]    cfg_high,
    input  logic [LO_W-1:0]    cfg_low,
    input  logic [HOLD_W-1:0]  cfg_hold,
    input  logic [SETUP_W-1:0] cfg_setup,
    output logic               smpl_clk,
    output logic               in_setup,
    output logic               in_hold
);

    logic             tick;
    logic             running;
    logic [DIV_W-1:0] div_lim;

    shclk_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .lim   (div_lim),
        .tick  (tick)
    );

    shclk_seq #(
        .DIV_W   (DIV_W),
        .HI_W    (HI_W),
        .LO_W    (LO_W),
        .HOLD_W  (HOLD_W),
        .SETUP_W (SETUP_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .tick      (tick),
        .cfg_div   (cfg_div),
        .cfg_high  (cfg_high),
        .cfg_low   (cfg_low),
        .cfg_hold  (cfg_hold),
        .cfg_setup (cfg_setup),
        .running   (running),
        .div_lim   (div_lim),
        .smpl_clk  (smpl_clk),
        .in_setup  (in_setup),
        .in_hold   (in_hold)
    );

endmodule

// File: rtl/dac_shclk_gen_chk.sv
module dac_shclk_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic tick,
    input logic smpl_clk,
    input logic in_setup,
    input logic in_hold
);

    p_idle_after_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!smpl_clk && !in_setup && !in_hold));

    p_start_in_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !in_setup && !in_hold) |=> in_setup);

    p_status_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({in_setup, in_hold}));

    p_hold_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_hold && enable) |=> in_hold);

    p_edge_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_setup || in_hold) && $past(in_setup || in_hold) && !$stable(smpl_clk))
            |-> $past(tick));

endmodule

bind dac_shclk_gen dac_shclk_gen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .tick     (tick),
    .smpl_clk (smpl_clk),
    .in_setup (in_setup),
    .in_hold  (in_hold)
);

// File: tb/dac_shclk_gen_bench.sv
module dac_shclk_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [5:0] cfg_div = '0;
    logic [3:0] cfg_high = '0;
    logic [3:0] cfg_low = '0;
    logic [3:0] cfg_hold = '0;
    logic [3:0] cfg_setup = '0;
    logic       smpl_clk, in_setup, in_hold;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    dac_shclk_gen u_dac_shclk_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .cfg_div   (cfg_div),
        .cfg_high  (cfg_high),
        .cfg_low   (cfg_low),
        .cfg_hold  (cfg_hold),
        .cfg_setup (cfg_setup),
        .smpl_clk  (smpl_clk),
        .in_setup  (in_setup),
        .in_hold   (in_hold)
    );

    function automatic int burst_len(int d, int h, int l, int n);
        return ((n == 0) ? 1 : n) * (h + l) * (d + 1);
    endfunction

    function automatic bit exp_level(int t, int d, int h, int l, int g, int n);
        int p = (h + l) * (d + 1);
        int hc = h * (d + 1);
        int b = burst_len(d, h, l, n);
        int v;
        if (t < b) return (t % p) < hc;
        v = (t - b) % ((g + 1) * p);
        return (v >= g * p) && ((v - g * p) < hc);
    endfunction

    task automatic check(string req, bit ok, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_case(string req, int d, int h, int l, int g, int n, int win);
        int bad_clk = 0, bad_st = 0, fa = 0, fe = 0, sa = 0, se = 0;
        @(negedge clk);
        cfg_div = 6'(d); cfg_high = 4'(h); cfg_low = 4'(l);
        cfg_hold = 4'(g); cfg_setup = 4'(n);
        enable = 1'b1;
        for (int t = 0; t < win; t++) begin
            @(negedge clk);
            if (smpl_clk !== exp_level(t, d, h, l, g, n)) begin
                if (bad_clk == 0) begin fa = t; fe = int'(exp_level(t, d, h, l, g, n)); end
                bad_clk++;
            end
            if ((in_setup !== (t < burst_len(d, h, l, n))) ||
                (in_hold !== (t >= burst_len(d, h, l, n)))) begin
                if (bad_st == 0) begin sa = {in_setup, in_hold}; se = (t < burst_len(d, h, l, n)) ? 2 : 1; end
                bad_st++;
            end
        end
        // R2 R3 R5 R6: waveform; fa/fe give first bad cycle and expected level
        check({req, " R2 clock waveform"}, bad_clk == 0, fa, fe);
        // R4 R10: status trace, {in_setup,in_hold}
        check({req, " R4 status trace"}, bad_st == 0, sa, se);
        enable = 1'b0;
        @(negedge clk);
        // R8: idle right after disable
        check("R8 idle after disable", {smpl_clk, in_setup, in_hold} == 3'b000,
              {smpl_clk, in_setup, in_hold}, 0);
        @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset outputs", {smpl_clk, in_setup, in_hold} == 3'b000,
              {smpl_clk, in_setup, in_hold}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {smpl_clk, in_setup, in_hold} == 3'b000,
              {smpl_clk, in_setup, in_hold}, 0);

        // directed corner cases
        run_case("R3 base", 0, 1, 1, 0, 1, 40);
        run_case("R5 gap", 1, 2, 3, 2, 2, 200);
        run_case("R6 high zero", 2, 0, 3, 1, 2, 120);
        run_case("R6 low zero", 1, 3, 0, 2, 3, 120);
        run_case("R4 setup zero", 0, 2, 2, 3, 0, 120);

        // constrained random
        for (int k = 0; k < 8; k++) begin
            int d = int'($urandom_range(0, 3));
            int h = int'($urandom_range(0, 4));
            int l = int'($urandom_range(0, 4));
            int g = int'($urandom_range(0, 3));
            int n = int'($urandom_range(0, 4));
            if (h + l == 0) l = 1;
            run_case("R2 random", d, h, l, g, n, 400);
        end

        // R7: all-zero period parks low, then recovers
        begin
            int bad = 0, rose = 0;
            @(negedge clk);
            cfg_div = 6'd2; cfg_high = '0; cfg_low = '0; cfg_hold = '0; cfg_setup = 4'd2;
            enable = 1'b1;
            for (int t = 0; t < 60; t++) begin
                @(negedge clk);
                if (smpl_clk !== 1'b0 || in_hold !== 1'b0) bad++;
            end
            check("R7 parked static low", bad == 0, bad, 0);
            cfg_high = 4'd2; cfg_low = 4'd1;
            for (int t = 0; t < 4; t++) begin
                @(negedge clk);
                if (smpl_clk === 1'b1) rose = 1;
            end
            check("R7 recovery after park", rose == 1, rose, 1);
            enable = 1'b0;
            repeat (2) @(negedge clk);
        end

        // R9: mid-period change keeps current widths
        begin
            bit [13:0] got;
            bit [13:0] expv = 14'b00_11_0000_111111;
            @(negedge clk);
            cfg_div = 6'd1; cfg_high = 4'd3; cfg_low = 4'd2; cfg_hold = '0; cfg_setup = 4'd15;
            enable = 1'b1;
            for (int t = 0; t < 14; t++) begin
                @(negedge clk);
                got[t] = smpl_clk;
                if (t == 2) cfg_high = 4'd1;
            end
            check("R9 boundary capture", got == expv, int'(got), int'(expv));
            enable = 1'b0;
            repeat (2) @(negedge clk);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule